// File: doc/BRIEF.md
# Dual-Mode Cascadable Pulse Accumulator

This block counts activity on one external input pin. A control register picks the behaviour. In event mode, each qualifying edge of the pin adds one to the count. In gated mode, a prescaled tick is counted while the pin stays at its active level. The tick arrives once every `PRESCALE` clocks and only while the timer enable input is high. The count is held in two byte-wide registers. When the block is enabled, the two bytes are chained into one counter of twice the width. When it is disabled, each byte counts edges on its own, under a separate enable bit.

The block raises an input-edge flag on each qualifying edge of the pin. It raises an overflow flag when the chained count wraps to zero. An interrupt request is driven when the overflow flag is set and the interrupt enable is set. Writing ones to a flag-clear port clears the flags. Either count byte can be loaded directly. The pin passes through a synchroniser before any edge is detected.

Top module: `pulse_acc`

## Requirements
- R1: After reset, the control readback, both count bytes, both flags and `irq` are all zero. Control bits 6:1 read back as written. Bits 7 and 0 always read 0. Bit layout: 6 = enable, 5 = mode (0 event, 1 gated), 4 = edge select, 3:2 = clock select (stored only), 1 = overflow interrupt enable.
- R2: With enable = 1, the low byte carries into the high byte, so `{cnt_hi,cnt_lo}` forms one 16-bit counter. `sep_en` has no effect in this state.
- R3: In event mode, edge select 0 counts falling edges of the pin and edge select 1 counts rising edges. Each qualifying edge adds exactly one. The new count is visible after the third rising clock edge that follows the pin change.
- R4: With enable = 0, each byte counts qualifying edges (chosen by edge select) only while its own enable is high. `sep_en[0]` enables the low byte and `sep_en[1]` enables the high byte. There is no carry between the bytes and no flag is set.
- R5: With enable = 1, the input-edge flag sets on every qualifying edge. In event mode this is each counted edge. In gated mode it is the trailing edge of the active level: falling when edge select is 0, rising when edge select is 1.
- R6: In gated mode, the counter adds one per prescaler tick while the synchronised pin is at its active level. The active level is high when edge select is 0 and low when edge select is 1. The first tick comes `PRESCALE` clocks after `timer_en` rises, and the next ticks follow every `PRESCALE` clocks.
- R7: While `timer_en` is 0, the prescaler is held at its start value and a gated count does not change.
- R8: The overflow flag sets when the chained count steps from all ones to zero.
- R9: `irq` is high exactly when the overflow flag is set and control bit 1 is set.
- R10: When `flg_we` is high, `flg_clr[1]` = 1 clears the input-edge flag and `flg_clr[0]` = 1 clears the overflow flag.
- R11: A write to a count byte loads `cnt_wdata` into that byte. The write also cancels any increment of both bytes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous input pin |
| timer_en | input | 1 | Timer running; enables the prescaler tick |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| flg_we | input | 1 | Flag-clear write strobe |
| flg_clr | input | 2 | Write-one-to-clear: bit 1 edge flag, bit 0 overflow flag |
| cnt_lo_we | input | 1 | Low count byte write strobe |
| cnt_hi_we | input | 1 | High count byte write strobe |
| cnt_wdata | input | CNT_W | Count write data |
| sep_en | input | 2 | Per-byte enables used when the block enable is 0 |
| ctl_q | output | 8 | Control register readback |
| cnt_lo | output | CNT_W | Low count byte |
| cnt_hi | output | CNT_W | High count byte |
| edge_flag | output | 1 | Input-edge flag |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong edge-select decode or a wrong synchroniser depth shows on the count bytes within three clocks of a pin change. It appears either as a missing step or as a step on the wrong edge. A broken carry or a broken wrap shows on the single clock where the low byte rolls over: `cnt_hi` fails to advance, or `ovf_flag` and `irq` stay low. A prescaler phase error shifts the gated count by one tick, which becomes visible only after a whole window of `PRESCALE` clocks.

// File: rtl/pa_pkg.sv
package pa_pkg;
   localparam int CTL_EN   = 6;
   localparam int CTL_MODE = 5;
   localparam int CTL_EDGE = 4;
   localparam int CTL_OVIE = 1;
   localparam logic [7:0] CTL_RW_MASK = 8'h7E;
   localparam int FLG_EDGE = 1;
   localparam int FLG_OVF  = 0;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sh;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pa_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         prev <= 1'b0;
      end else begin
         sh   <= {sh[STAGES-2:0], d};
         prev <= sh[STAGES-1];
      end
   end

   assign lvl  = sh[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/pa_tick_div.sv
module pa_tick_div #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);
   logic [DW-1:0] cnt;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("pa_tick_div: DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run)  cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/pa_byte.sv
module pa_byte #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         inc,
   output logic [W-1:0] q,
   output logic         carry
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (we)  q <= wdata;
      else if (inc) q <= q + 1'b1;
   end

   assign carry = inc & ~we & (&q);
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
   import pa_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PRESCALE    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             timer_en,
   input  logic             ctl_we,
   input  logic [7:0]       ctl_wdata,
   input  logic             flg_we,
   input  logic [1:0]       flg_clr,
   input  logic             cnt_lo_we,
   input  logic             cnt_hi_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [1:0]       sep_en,
   output logic [7:0]       ctl_q,
   output logic [CNT_W-1:0] cnt_lo,
   output logic [CNT_W-1:0] cnt_hi,
   output logic             edge_flag,
   output logic             ovf_flag,
   output logic             irq
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pulse_acc: CNT_W must be at least 2");
      end
   endgenerate

   logic lvl, rise, fall, tick;
   logic en, mode, esel, ovie;
   logic qual, active, any_we, casc_step, sep_step;
   logic inc_lo, inc_hi, carry_lo, carry_hi, wrap;

   pa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   pa_tick_div #(.DIV(PRESCALE)) u_div (
      .clk(clk), .rst_n(rst_n), .run(timer_en), .tick(tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= ctl_wdata & CTL_RW_MASK;
   end

   assign en   = ctl_q[CTL_EN];
   assign mode = ctl_q[CTL_MODE];
   assign esel = ctl_q[CTL_EDGE];
   assign ovie = ctl_q[CTL_OVIE];

   // one edge serves both modes: the counted event edge equals the gated trailing edge
   assign qual      = esel ? rise : fall;
   assign active    = esel ? ~lvl : lvl;
   assign any_we    = cnt_lo_we | cnt_hi_we;
   assign casc_step = en & ~any_we & (mode ? (active & tick) : qual);
   assign sep_step  = ~en & ~any_we & qual;

   assign inc_lo = en ? casc_step : (sep_step & sep_en[0]);
   assign inc_hi = en ? carry_lo  : (sep_step & sep_en[1]);
   assign wrap   = en & carry_hi;

   pa_byte #(.W(CNT_W)) u_lo (
      .clk(clk), .rst_n(rst_n), .we(cnt_lo_we), .wdata(cnt_wdata),
      .inc(inc_lo), .q(cnt_lo), .carry(carry_lo)
   );

   pa_byte #(.W(CNT_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .we(cnt_hi_we), .wdata(cnt_wdata),
      .inc(inc_hi), .q(cnt_hi), .carry(carry_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_flag <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         edge_flag <= (edge_flag & ~(flg_we & flg_clr[FLG_EDGE])) | (en & qual);
         ovf_flag  <= (ovf_flag  & ~(flg_we & flg_clr[FLG_OVF]))  | wrap;
      end
   end

   assign irq = ovf_flag & ovie;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             timer_en,
   input logic             cnt_lo_we,
   input logic             cnt_hi_we,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic [7:0]       ctl_q,
   input logic [CNT_W-1:0] cnt_lo,
   input logic [CNT_W-1:0] cnt_hi,
   input logic             edge_flag,
   input logic             ovf_flag,
   input logic             irq
);
   logic [2*CNT_W-1:0] cat;
   assign cat = {cnt_hi, cnt_lo};

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ovf_flag); // R9
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[1] |-> !irq); // R9
   AST_EDGE_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[6] && !edge_flag) |=> !edge_flag); // R4
   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (cat == '0)); // R8
   AST_GATED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[6] && ctl_q[5] && !timer_en && !cnt_lo_we && !cnt_hi_we) |=> $stable(cat)); // R7
   AST_CASC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[6] && !cnt_lo_we && !cnt_hi_we) |=>
         (cat == $past(cat) || cat == $past(cat) + 1'b1)); // R2
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_lo_we |=> cnt_lo == $past(cnt_wdata)); // R11
endmodule

bind pulse_acc pa_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .timer_en(timer_en),
   .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_wdata(cnt_wdata),
   .ctl_q(ctl_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
   .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/sim_pulse_acc.sv
`timescale 1ns/1ps
module sim_pulse_acc;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_in = 1'b0, timer_en = 1'b0;
   logic ctl_we = 1'b0, flg_we = 1'b0, cnt_lo_we = 1'b0, cnt_hi_we = 1'b0;
   logic [7:0] ctl_wdata = '0, cnt_wdata = '0;
   logic [1:0] flg_clr = '0, sep_en = '0;
   logic [7:0] ctl_q, cnt_lo, cnt_hi;
   logic edge_flag, ovf_flag, irq;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pulse_acc u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_en(timer_en),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .flg_we(flg_we), .flg_clr(flg_clr),
      .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we), .cnt_wdata(cnt_wdata),
      .sep_en(sep_en), .ctl_q(ctl_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic wr_cnt(logic [7:0] hi, logic [7:0] lo);
      @(negedge clk); cnt_hi_we = 1'b1; cnt_wdata = hi;
      @(negedge clk); cnt_hi_we = 1'b0; cnt_lo_we = 1'b1; cnt_wdata = lo;
      @(negedge clk); cnt_lo_we = 1'b0;
   endtask

   task automatic clr_flags(logic [1:0] m);
      @(negedge clk); flg_we = 1'b1; flg_clr = m;
      @(negedge clk); flg_we = 1'b0; flg_clr = '0;
   endtask

   task automatic pulse();
      @(negedge clk); pin_in = 1'b1; wait_n(6);
      pin_in = 1'b0; wait_n(6);
   endtask

   task automatic t_reset();
      chk("R1 ctl reset", ctl_q, 0);
      chk("R1 count reset", {cnt_hi, cnt_lo}, 0);
      chk("R1 flags/irq reset", {edge_flag, ovf_flag, irq}, 0);
      wr_ctl(8'hFF);
      chk("R1 ctl readback mask", ctl_q, 8'h7E);
      wr_ctl(8'h00);
   endtask

   task automatic t_event_rise();
      wr_ctl(8'h50);
      sep_en = 2'b00;
      repeat (5) pulse();
      chk("R3 rising-edge count (R2 sep_en ignored)", {cnt_hi, cnt_lo}, 5);
      chk("R5 edge flag in event mode", edge_flag, 1);
   endtask

   task automatic t_event_fall();
      wr_cnt(8'h00, 8'h00);
      wr_ctl(8'h40);
      repeat (3) pulse();
      chk("R3 falling-edge count", {cnt_hi, cnt_lo}, 3);
   endtask

   task automatic t_cascade();
      wr_cnt(8'h00, 8'hFF);
      pulse();
      chk("R2 low byte carries into high", {cnt_hi, cnt_lo}, 16'h0100);
      chk("R8 no overflow on inner carry", ovf_flag, 0);
   endtask

   task automatic t_wrap();
      wr_ctl(8'h42);
      wr_cnt(8'hFF, 8'hFF);
      pulse();
      chk("R8 wrap to zero", {cnt_hi, cnt_lo}, 0);
      chk("R8 overflow flag", ovf_flag, 1);
      chk("R9 irq with enable", irq, 1);
      wr_ctl(8'h40);
      chk("R9 irq masked", irq, 0);
      clr_flags(2'b01);
      chk("R10 overflow cleared, edge kept", {edge_flag, ovf_flag}, 2'b10);
      clr_flags(2'b10);
      chk("R10 edge flag cleared", edge_flag, 0);
   endtask

   task automatic t_separate();
      wr_ctl(8'h00);
      wr_cnt(8'h05, 8'hFF);
      sep_en = 2'b01;
      pulse();
      chk("R4 low only, no carry", {cnt_hi, cnt_lo}, 16'h0500);
      chk("R4 no flags when disabled", {edge_flag, ovf_flag}, 0);
      sep_en = 2'b11;
      pulse();
      chk("R4 both bytes count alone", {cnt_hi, cnt_lo}, 16'h0601);
      sep_en = 2'b00;
      pulse();
      chk("R4 no count without byte enable", {cnt_hi, cnt_lo}, 16'h0601);
   endtask

   task automatic t_gated();
      wr_cnt(8'h00, 8'h00);
      wr_ctl(8'h60);
      @(negedge clk); pin_in = 1'b1; wait_n(4);
      chk("R5 no flag on leading edge", edge_flag, 0);
      timer_en = 1'b1;
      wait_n(320);
      timer_en = 1'b0;
      chk("R6 five ticks while pin high", {cnt_hi, cnt_lo}, 5);
      wait_n(100);
      chk("R7 frozen with timer off", {cnt_hi, cnt_lo}, 5);
      pin_in = 1'b0; wait_n(4);
      chk("R5 trailing falling edge sets flag", edge_flag, 1);
      timer_en = 1'b1;
      wait_n(130);
      timer_en = 1'b0;
      chk("R6 no ticks while pin inactive", {cnt_hi, cnt_lo}, 5);
      clr_flags(2'b11);
   endtask

   task automatic t_priority();
      wr_ctl(8'h50);
      wr_cnt(8'h00, 8'h10);
      @(negedge clk); pin_in = 1'b1;
      wait_n(2);
      cnt_lo_we = 1'b1; cnt_wdata = 8'h40;
      @(negedge clk); cnt_lo_we = 1'b0;
      wait_n(3);
      chk("R11 write wins over increment", {cnt_hi, cnt_lo}, 16'h0040);
      pin_in = 1'b0; wait_n(5);
      chk("R3 falling edge not counted when rising selected", {cnt_hi, cnt_lo}, 16'h0040);
   endtask

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_event_rise();
      t_event_fall();
      t_cascade();
      t_wrap();
      t_separate();
      t_gated();
      t_priority();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule